// File: doc/BRIEF.md
# Multiplexed Bus Target Controller

This block is the target side of a 32-bit parallel bus. Address and data share one set of lines. An initiator starts a transaction by asserting the cycle strobe. In that first cycle the lines carry the byte address and the 4-bit command code. In each later cycle they carry data, while the command lines carry active-low byte enables. A word moves in every cycle where the initiator-ready and target-ready strobes are both low. All handshake pins are active-low and are sampled on the rising clock edge only.

The controller captures the address and command and decides in the next cycle whether to claim the transaction. It claims I/O accesses that fall inside a byte window, and configuration accesses that arrive with the select input high and a word-aligned address. It claims at the second cycle after the address cycle. An I/O access whose enabled bytes spill past the window is refused with a target-abort, and no data moves. Two small register files hold the data: one for configuration space and one for the I/O window. Bursts step through consecutive words, with one wait cycle between data phases.

Top module: `pbt_target`

## Requirements
- R1: During and after reset, `claim_no`, `tgt_rdy_no` and `halt_no` are high and `adbus_oe_o` is low.
- R2: A transaction starts only when `cyc_ni` is low and the previous cycle had both `cyc_ni` and `mst_rdy_ni` high (bus idle). In the first cycle after the address cycle, `claim_no` stays high and `adbus_oe_o` stays low (turnaround). `claim_no` goes low in the second cycle after the address cycle.
- R3: A data phase completes on a rising edge where `mst_rdy_ni` and `tgt_rdy_no` are both low. A write stores `adbus_i` only into the byte lanes whose active-low enable on `cmd_be_i` is 0, with lane k being bits 8k+7..8k. A read presents the word on `adbus_o` with `adbus_oe_o` high while `tgt_rdy_no` is low.
- R4: Once `tgt_rdy_no` or `halt_no` is low, `claim_no`, `tgt_rdy_no` and `halt_no` keep their values until the current data phase completes.
- R5: Configuration read is command 4'b1010 and configuration write is 4'b1011. Either is claimed only if `sel_i` is high and address bits [1:0] are 00 in the address cycle. Address bits [7:2] select the register.
- R6: Configuration registers with index CFG_WORDS (default 8) or above are still claimed. They read as zero and ignore writes.
- R7: I/O read is 4'b0010 and I/O write is 4'b0011. These are claimed when the byte address lies in [IO_BASE, IO_BASE+IO_LEN) (default 0x1000, 14 bytes). Each register holds one 32-bit word at IO_BASE+4*n.
- R8: If any enabled byte of an I/O data phase lies outside the window, the target raises `claim_no`, pulls `halt_no` low and keeps `tgt_rdy_no` high. Nothing is written. `halt_no` is released after an edge that samples `cyc_ni` high and `mst_rdy_ni` low.
- R9: If `cyc_ni` is still low when a data phase completes, `tgt_rdy_no` goes high for exactly one cycle while `claim_no` stays low. The next phase then uses the address plus 4. If `cyc_ni` is high at completion, all outputs release in the next cycle.
- R10: Other commands are ignored with no response. So are transactions that start without an idle cycle before them, and configuration accesses with `sel_i` low or address bits [1:0] other than 00. Ignored writes change no register.
- R11: `adbus_oe_o` is high only while the target is claiming a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adbus_i | input | 32 | Address/data lines as seen by the target |
| adbus_o | output | 32 | Read data driven onto the lines |
| adbus_oe_o | output | 1 | Output enable for `adbus_o` |
| cmd_be_i | input | 4 | Command code in the address cycle, active-low byte enables after it |
| cyc_ni | input | 1 | Cycle strobe from the initiator, active low |
| mst_rdy_ni | input | 1 | Initiator ready, active low |
| sel_i | input | 1 | Configuration select, active high |
| claim_no | output | 1 | Target has claimed the transaction, active low |
| tgt_rdy_no | output | 1 | Target ready, active low |
| halt_no | output | 1 | Target requests termination, active low |

## Verification
The hardest situations to reach are those where the initiator withholds readiness while the target already has a response on the pins. One is a read with data presented and initiator-ready held high for an extra cycle. The other is an abort with the cycle strobe still held low. Directed sequences hold `mst_rdy_ni` high across these cycles and check that the strobes and the read word do not move. A further sequence starts a well-formed configuration read right after another agent's final phase, with no idle cycle between. The target must stay silent there, even though the transaction itself would otherwise be claimed.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_XFER,
    ST_WAIT,
    ST_ABT
  } st_e;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
endpackage

// File: rtl/pbt_decode.sv
module pbt_decode
  import pbt_pkg::*;
#(
  parameter logic [31:0] IO_BASE = 32'h0000_1000,
  parameter int unsigned IO_LEN  = 14
) (
  input  logic [31:0] addr_i,
  input  logic [3:0]  cmd_i,
  input  logic        sel_i,
  input  logic [3:0]  be_i,
  output logic        hit_o,
  output logic        is_io_o,
  output logic        is_wr_o,
  output logic        abort_o
);
  localparam logic [32:0] IO_LO = {1'b0, IO_BASE};
  localparam logic [32:0] IO_HI = IO_LO + 33'(IO_LEN);

  logic       is_cfg;
  logic       io_in;
  logic [3:0] lane_out;

  assign is_io_o = (cmd_i == CMD_IO_RD) || (cmd_i == CMD_IO_WR);
  assign is_cfg  = (cmd_i == CMD_CFG_RD) || (cmd_i == CMD_CFG_WR);
  assign is_wr_o = cmd_i[0] & (is_io_o | is_cfg);
  assign io_in   = ({1'b0, addr_i} >= IO_LO) && ({1'b0, addr_i} < IO_HI);
  assign hit_o   = (is_io_o & io_in) | (is_cfg & sel_i & (addr_i[1:0] == 2'b00));

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [32:0] lane_addr;
    assign lane_addr   = {1'b0, addr_i[31:2], 2'b00} + 33'(k);
    assign lane_out[k] = be_i[k] & ((lane_addr < IO_LO) || (lane_addr >= IO_HI));
  end

  assign abort_o = is_io_o & (|lane_out);
endmodule

// File: rtl/pbt_regfile.sv
module pbt_regfile #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned IW    = 6,
  localparam int unsigned AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [WORDS];
  logic        in_rng;

  assign in_rng  = ({{(64-IW){1'b0}}, idx_i} < 64'(WORDS));
  assign rdata_o = in_rng ? mem_q[idx_i[AW-1:0]] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < int'(WORDS); w++) mem_q[w] <= '0;
    end else if (we_i && in_rng) begin
      for (int b = 0; b < 4; b++)
        if (be_i[b]) mem_q[idx_i[AW-1:0]][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end
endmodule

// File: rtl/pbt_target.sv
module pbt_target
  import pbt_pkg::*;
#(
  parameter logic [31:0] IO_BASE   = 32'h0000_1000,
  parameter int unsigned IO_LEN    = 14,
  parameter int unsigned CFG_WORDS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] adbus_i,
  output logic [31:0] adbus_o,
  output logic        adbus_oe_o,
  input  logic [3:0]  cmd_be_i,
  input  logic        cyc_ni,
  input  logic        mst_rdy_ni,
  input  logic        sel_i,
  output logic        claim_no,
  output logic        tgt_rdy_no,
  output logic        halt_no
);
  localparam int unsigned IO_WORDS = (IO_LEN + 3) / 4;

  st_e         st_q;
  logic [31:0] addr_q, ad_q, rd_data, cfg_rd, io_rd;
  logic [3:0]  cmd_q, be;
  logic        sel_q, prev_idle_q;
  logic        claim_q, trdy_q, halt_q, oe_q;
  logic        cyc, mrdy, start;
  logic        hit, is_io, is_wr, abort;
  logic        we, cfg_we, io_we;
  logic [29:0] io_idx;

  assign cyc   = ~cyc_ni;
  assign mrdy  = ~mst_rdy_ni;
  assign be    = ~cmd_be_i;
  assign start = (st_q == ST_IDLE) && cyc && prev_idle_q;

  pbt_decode #(.IO_BASE(IO_BASE), .IO_LEN(IO_LEN)) u_dec (
    .addr_i (addr_q),
    .cmd_i  (cmd_q),
    .sel_i  (sel_q),
    .be_i   (be),
    .hit_o  (hit),
    .is_io_o(is_io),
    .is_wr_o(is_wr),
    .abort_o(abort)
  );

  assign we     = (st_q == ST_XFER) && mrdy && is_wr;
  assign cfg_we = we & ~is_io;
  assign io_we  = we & is_io;
  assign io_idx = addr_q[31:2] - IO_BASE[31:2];

  pbt_regfile #(.WORDS(CFG_WORDS), .IW(6)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we),
    .idx_i  (addr_q[7:2]),
    .be_i   (be),
    .wdata_i(adbus_i),
    .rdata_o(cfg_rd)
  );

  pbt_regfile #(.WORDS(IO_WORDS), .IW(30)) u_io (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (io_we),
    .idx_i  (io_idx),
    .be_i   (be),
    .wdata_i(adbus_i),
    .rdata_o(io_rd)
  );

  assign rd_data = is_io ? io_rd : cfg_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      cmd_q       <= '0;
      sel_q       <= 1'b0;
      prev_idle_q <= 1'b1;
      claim_q     <= 1'b0;
      trdy_q      <= 1'b0;
      halt_q      <= 1'b0;
      oe_q        <= 1'b0;
      ad_q        <= '0;
    end else begin
      prev_idle_q <= cyc_ni & mst_rdy_ni;
      unique case (st_q)
        ST_IDLE: if (start) begin
          addr_q <= adbus_i;
          cmd_q  <= cmd_be_i;
          sel_q  <= sel_i;
          st_q   <= ST_DEC;
        end
        ST_DEC, ST_WAIT: begin
          if (st_q == ST_DEC && !hit) begin
            st_q <= ST_IDLE;
          end else if (abort) begin
            st_q    <= ST_ABT;
            claim_q <= 1'b0;
            halt_q  <= 1'b1;
            trdy_q  <= 1'b0;
            oe_q    <= 1'b0;
          end else begin
            st_q    <= ST_XFER;
            claim_q <= 1'b1;
            trdy_q  <= 1'b1;
            oe_q    <= ~is_wr;
            ad_q    <= rd_data;
          end
        end
        ST_XFER: if (mrdy) begin
          trdy_q <= 1'b0;
          if (!cyc) begin
            st_q    <= ST_IDLE;
            claim_q <= 1'b0;
            oe_q    <= 1'b0;
          end else begin
            addr_q <= addr_q + 32'd4;
            st_q   <= ST_WAIT;
          end
        end
        ST_ABT: if (mrdy && !cyc) begin
          halt_q <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign claim_no   = ~claim_q;
  assign tgt_rdy_no = ~trdy_q;
  assign halt_no    = ~halt_q;
  assign adbus_o    = ad_q;
  assign adbus_oe_o = oe_q;

  // R2: medium decode, nothing driven in the turnaround cycle
  a_r2_medium_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (!claim_q && !oe_q));

  // R4: response strobes frozen while the initiator waits
  a_r4_hold_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((trdy_q || halt_q) && !mrdy) |=> ($stable(claim_q) && $stable(trdy_q) && $stable(halt_q)));

  // R8: abort form and no write during abort
  a_r8_abort_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> (!claim_q && !trdy_q && !we));

  // R5: configuration claim qualified by select and alignment
  a_r5_cfg_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_q && !is_io) |-> (sel_q && addr_q[1:0] == 2'b00));

  // R11: drive only a claimed read
  a_r11_oe_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (claim_q && !is_wr));

  // R3: register writes only with target ready shown
  a_r3_write_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we || io_we) |-> trdy_q);
endmodule

// File: tb/sim_pbt_target.sv
`timescale 1ns/1ps
module sim_pbt_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] adbus_i = '0;
  logic [31:0] adbus_o;
  logic        adbus_oe;
  logic [3:0]  cmd_be = 4'hF;
  logic        cyc_n = 1'b1;
  logic        mrdy_n = 1'b1;
  logic        sel = 1'b0;
  logic        claim_n, trdy_n, halt_n;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  pbt_target u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .adbus_i   (adbus_i),
    .adbus_o   (adbus_o),
    .adbus_oe_o(adbus_oe),
    .cmd_be_i  (cmd_be),
    .cyc_ni    (cyc_n),
    .mst_rdy_ni(mrdy_n),
    .sel_i     (sel),
    .claim_no  (claim_n),
    .tgt_rdy_no(trdy_n),
    .halt_no   (halt_n)
  );

  // {cmd, addr, sel, be_n, wdata, kind(0 none,1 claim,2 abort), expected read, req}
  localparam int NV = 20;
  localparam logic [110:0] VEC [NV] = '{
    {4'hB, 32'h0000_0000, 1'b1, 4'h0, 32'hDEAD_BEEF, 2'd1, 32'h0, 4'd3},        // R3 cfg write
    {4'hA, 32'h0000_0000, 1'b1, 4'h0, 32'h0,         2'd1, 32'hDEAD_BEEF, 4'd3}, // R3 cfg read
    {4'hB, 32'h0000_0004, 1'b1, 4'hA, 32'h1122_3344, 2'd1, 32'h0, 4'd3},        // R3 lanes 0,2
    {4'hA, 32'h0000_0004, 1'b1, 4'h0, 32'h0,         2'd1, 32'h0022_0044, 4'd3},
    {4'hB, 32'h0000_0050, 1'b1, 4'h0, 32'h0000_0055, 2'd1, 32'h0, 4'd6},        // R6 unimplemented
    {4'hA, 32'h0000_0050, 1'b1, 4'h0, 32'h0,         2'd1, 32'h0, 4'd6},
    {4'hA, 32'h0000_0000, 1'b0, 4'h0, 32'h0,         2'd0, 32'h0, 4'd5},        // R5 no select
    {4'hA, 32'h0000_0002, 1'b1, 4'h0, 32'h0,         2'd0, 32'h0, 4'd5},        // R5 low bits
    {4'hB, 32'h0000_0000, 1'b0, 4'h0, 32'h0,         2'd0, 32'h0, 4'd10},       // R10 ignored write
    {4'hA, 32'h0000_0000, 1'b1, 4'h0, 32'h0,         2'd1, 32'hDEAD_BEEF, 4'd10},
    {4'h3, 32'h0000_1004, 1'b0, 4'h0, 32'hCAFE_F00D, 2'd1, 32'h0, 4'd7},        // R7 io write
    {4'h2, 32'h0000_1004, 1'b0, 4'h0, 32'h0,         2'd1, 32'hCAFE_F00D, 4'd7},
    {4'h3, 32'h0000_100C, 1'b0, 4'hC, 32'h0000_ABCD, 2'd1, 32'h0, 4'd7},        // R7 edge word
    {4'h3, 32'h0000_100C, 1'b0, 4'h0, 32'hFFFF_FFFF, 2'd2, 32'h0, 4'd8},        // R8 spill write
    {4'h2, 32'h0000_100C, 1'b0, 4'hC, 32'h0,         2'd1, 32'h0000_ABCD, 4'd8},
    {4'h2, 32'h0000_100C, 1'b0, 4'h0, 32'h0,         2'd2, 32'h0, 4'd8},        // R8 spill read
    {4'h2, 32'h0000_1010, 1'b0, 4'h0, 32'h0,         2'd0, 32'h0, 4'd7},        // R7 above window
    {4'h6, 32'h0000_1000, 1'b1, 4'h0, 32'h0,         2'd0, 32'h0, 4'd10},       // R10 other command
    {4'h2, 32'h0000_0FFC, 1'b0, 4'h0, 32'h0,         2'd0, 32'h0, 4'd7},        // R7 below window
    {4'h2, 32'h0000_1002, 1'b0, 4'h3, 32'h0,         2'd1, 32'h0, 4'd7}         // R7 unaligned start
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(claim_n && trdy_n && halt_n && !adbus_oe, tag,
        {28'h0, claim_n, trdy_n, halt_n, adbus_oe}, 32'hE);
  endtask

  task automatic txn(input logic [110:0] v);
    logic [3:0]  c   = v[110:107];
    logic [1:0]  k   = v[37:36];
    logic [31:0] exp = v[35:4];
    string       tag = $sformatf("R%0d vec", v[3:0]);
    @(negedge clk);
    cyc_n = 1'b0; mrdy_n = 1'b1; adbus_i = v[106:75]; cmd_be = c; sel = v[74];
    @(negedge clk);
    cyc_n = 1'b1; mrdy_n = 1'b0; cmd_be = v[73:70]; adbus_i = v[69:38]; sel = 1'b0;
    chk(claim_n && !adbus_oe, "R2 turnaround", {30'h0, claim_n, adbus_oe}, 32'h2);
    @(negedge clk);
    if (k == 2'd1) begin
      chk(!claim_n && !trdy_n && halt_n, tag, {29'h0, claim_n, trdy_n, halt_n}, 32'h1);
      if (!c[0]) chk(adbus_oe && adbus_o == exp, tag, adbus_o, exp);
    end else if (k == 2'd2) begin
      chk(claim_n && trdy_n && !halt_n && !adbus_oe, tag, {29'h0, claim_n, trdy_n, halt_n}, 32'h6);
    end else begin
      chk(claim_n && trdy_n && halt_n, tag, {29'h0, claim_n, trdy_n, halt_n}, 32'h7);
      @(negedge clk);
      chk(claim_n && trdy_n && halt_n, tag, {29'h0, claim_n, trdy_n, halt_n}, 32'h7);
    end
    @(negedge clk);
    mrdy_n = 1'b1; cmd_be = 4'hF;
    chk_idle("R9 release");
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");

    for (int i = 0; i < NV; i++) txn(VEC[i]);

    // R9 burst write into cfg words 2,3
    @(negedge clk);
    cyc_n = 1'b0; adbus_i = 32'h8; cmd_be = 4'hB; sel = 1'b1;
    @(negedge clk);
    mrdy_n = 1'b0; cmd_be = 4'h0; adbus_i = 32'h0102_0304; sel = 1'b0;
    @(negedge clk);
    chk(!claim_n && !trdy_n, "R9 first phase", {30'h0, claim_n, trdy_n}, 32'h0);
    @(negedge clk);
    chk(!claim_n && trdy_n, "R9 wait cycle", {30'h0, claim_n, trdy_n}, 32'h1);
    cyc_n = 1'b1; adbus_i = 32'hA5A5_5A5A;
    @(negedge clk);
    chk(!claim_n && !trdy_n, "R9 second phase", {30'h0, claim_n, trdy_n}, 32'h0);
    @(negedge clk);
    mrdy_n = 1'b1; cmd_be = 4'hF;
    chk_idle("R9 burst end");
    @(negedge clk);

    // R4 burst read with initiator wait
    @(negedge clk);
    cyc_n = 1'b0; adbus_i = 32'h8; cmd_be = 4'hA; sel = 1'b1;
    @(negedge clk);
    cmd_be = 4'h0; sel = 1'b0;
    @(negedge clk);
    chk(!trdy_n && adbus_oe && adbus_o == 32'h0102_0304, "R3 burst word0", adbus_o, 32'h0102_0304);
    @(negedge clk);
    chk(!claim_n && !trdy_n && halt_n && adbus_o == 32'h0102_0304, "R4 held read", adbus_o, 32'h0102_0304);
    mrdy_n = 1'b0;
    @(negedge clk);
    chk(trdy_n && !claim_n, "R9 read wait", {30'h0, claim_n, trdy_n}, 32'h1);
    cyc_n = 1'b1;
    @(negedge clk);
    chk(!trdy_n && adbus_o == 32'hA5A5_5A5A, "R9 burst word1", adbus_o, 32'hA5A5_5A5A);
    @(negedge clk);
    mrdy_n = 1'b1; cmd_be = 4'hF;
    chk_idle("R11 released");
    @(negedge clk);

    // R8 abort held while the initiator waits
    @(negedge clk);
    cyc_n = 1'b0; adbus_i = 32'h100C; cmd_be = 4'h3;
    @(negedge clk);
    cmd_be = 4'h0; adbus_i = 32'h1234_5678;
    @(negedge clk);
    chk(!halt_n && claim_n && trdy_n, "R8 abort", {29'h0, claim_n, trdy_n, halt_n}, 32'h6);
    @(negedge clk);
    chk(!halt_n && claim_n && trdy_n, "R4 abort held", {29'h0, claim_n, trdy_n, halt_n}, 32'h6);
    cyc_n = 1'b1; mrdy_n = 1'b0;
    @(negedge clk);
    mrdy_n = 1'b1; cmd_be = 4'hF;
    chk_idle("R8 abort release");
    @(negedge clk);
    txn({4'h2, 32'h0000_100C, 1'b0, 4'hC, 32'h0, 2'd1, 32'h0000_ABCD, 4'd8});

    // R2 start without a preceding idle cycle is ignored
    @(negedge clk);
    cyc_n = 1'b1; mrdy_n = 1'b0;
    @(negedge clk);
    cyc_n = 1'b0; mrdy_n = 1'b1; adbus_i = 32'h0; cmd_be = 4'hA; sel = 1'b1;
    @(negedge clk);
    mrdy_n = 1'b0; cyc_n = 1'b1; cmd_be = 4'h0; sel = 1'b0;
    @(negedge clk);
    chk(claim_n && trdy_n, "R2 no idle", {30'h0, claim_n, trdy_n}, 32'h3);
    @(negedge clk);
    chk(claim_n && trdy_n, "R2 no idle later", {30'h0, claim_n, trdy_n}, 32'h3);
    mrdy_n = 1'b1; cmd_be = 4'hF;
    @(negedge clk);
    chk_idle("R1 quiet end");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule